// File: doc/BRIEF.md
# Set/Clear Control Register Bank for a USB Link-to-PHY Interface

This block is the register file that sits behind the link-side register interface of a USB transceiver. It keeps five eight-bit control registers. Each one answers at three neighbouring addresses. The first address replaces the value, the second ORs new bits in, and the third knocks bits out. This lets the link change a single field in one write, without a read-modify-write. Two of the five registers gate interrupt sources: one passes rising edges and one passes falling edges. Together they feed a sticky interrupt latch that the link reads and then clears by writing ones.

The bank also samples the live transceiver status lines: VBUS valid, session valid, session end, ID ground and the two-bit line state. Any change on them raises a one-cycle pulse, which the bus front end uses to schedule a status byte towards the link. A read-only debug location shows the sampled line state. Identification bytes occupy the bottom four addresses.

The bus protocol itself, meaning the nibble transfers, turnaround and command decoding, belongs to a neighbouring block. That block presents a flat write strobe with address and data, plus a combinational read port.

Top module: `phy_regbank`

## Requirements
- R1: After reset, the function register reads 41h, the interface register 00h, the OTG register 06h, and both edge-enable registers 1Eh. The interrupt latch reads 00h, and `irq_pending` and `status_change` are low.
- R2: Addresses 00h and 01h return the low and high bytes of the vendor code. Addresses 02h and 03h return the low and high bytes of the product code. Writes to these addresses change nothing.
- R3: A write to a register's base address loads the data ANDed with that register's implemented-bit mask, and unimplemented bits read 0. The masks are: function 7Fh (bit 7 reserved, bit 6 active-low suspend), interface 9Fh (bit 7 turns off interface protection), OTG FFh (bit 7 selects the external VBUS indicator), and edge enables 1Eh.
- R4: A write to base+1 ORs the masked data into the register.
- R5: A write to base+2 clears every register bit where the data has a 1.
- R6: The base addresses are 04h (function), 07h (interface), 0Ah (OTG), 0Dh (rising enables) and 10h (falling enables). Reading any of the three addresses of a register returns its value, and the first three registers also drive their own output ports.
- R7: Interrupt bits are bit 1 VBUS valid, bit 2 session valid, bit 3 session end and bit 4 ID ground. A rising edge of a source whose rising-enable bit is set, or a falling edge whose falling-enable bit is set, sets the matching latch bit. The latch reads at 13h and shows the edge two clock edges after the input changes. A disabled edge sets nothing.
- R8: Writing to 14h clears the latch bits where the data has a 1 and leaves the other bits alone. An event on the same edge wins over the clear. Writes to 13h have no effect.
- R9: `irq_pending` is high exactly while any latch bit is set.
- R10: A change on any of the six live status inputs drives `status_change` high for exactly one cycle, starting one clock edge after the change.
- R11: Address 15h returns the sampled line state in bits 1:0 and zero above them. It reads 00h after reset.
- R12: Reads of 16h to 3Fh return 00h. Writes there leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| vbus_valid | input | 1 | Live VBUS-valid comparator |
| sess_valid | input | 1 | Live session-valid comparator |
| sess_end | input | 1 | Live session-end comparator |
| id_gnd | input | 1 | Live ID-pin-grounded indication |
| line_state | input | 2 | Live line state |
| func_ctrl | output | 8 | Function control register |
| intf_ctrl | output | 8 | Interface control register |
| otg_ctrl | output | 8 | OTG control register |
| irq_pending | output | 1 | Any interrupt latch bit set |
| status_change | output | 1 | One-cycle request for a status byte |

## Verification
Every control register is swept through all 256 data values. The bench writes each value, then sets a rotated pattern, then clears a third pattern, and checks the result against an arithmetic model. This separates a wrong alias offset, a wrong mask and a swapped set or clear. Each interrupt source is toggled under all four combinations of its two enable bits. That shows whether edge polarity is mixed up or an enable is ignored. The bench also clears the latch partly, and once on the very edge an event arrives, to expose lost or stale latch bits. Line-state stepping, writes to read-only and unmapped addresses, and a read sweep of the unmapped range cover the pulse, the debug view and R12.

// File: rtl/phy_regbank_pkg.sv
package phy_regbank_pkg;

   localparam int REG_W   = 8;
   localparam int NUM_CTL = 5;
   localparam int ALIASES = 3;

   typedef enum logic [1:0] {
      ACC_LOAD = 2'd0,
      ACC_OR   = 2'd1,
      ACC_ANDN = 2'd2,
      ACC_IDLE = 2'd3
   } acc_e;

   function automatic logic [REG_W-1:0] apply_acc(input acc_e a,
                                                  input logic [REG_W-1:0] cur,
                                                  input logic [REG_W-1:0] d);
      case (a)
         ACC_LOAD: return d;
         ACC_OR:   return cur | d;
         ACC_ANDN: return cur & ~d;
         default:  return cur;
      endcase
   endfunction

endpackage

// File: rtl/phy_regbank_alias.sv
module phy_regbank_alias
   import phy_regbank_pkg::*;
#(
   parameter int               ADDR_W = 6,
   parameter int               BASE   = 4,
   parameter logic [REG_W-1:0] MASK   = 8'hFF,
   parameter logic [REG_W-1:0] RST    = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  q
);

   localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE + ALIASES - 1);

   logic              hit;
   logic [ADDR_W-1:0] off;
   acc_e              acc;

   assign hit = wr_en && (wr_addr >= LO) && (wr_addr <= HI);
   assign off = wr_addr - LO;
   assign acc = hit ? acc_e'(off[1:0]) : ACC_IDLE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST & MASK;
      else        q <= apply_acc(acc, q, wr_data) & MASK;
   end

endmodule

// File: rtl/phy_regbank_sense.sv
module phy_regbank_sense #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] live,
   output logic [W-1:0] now_q,
   output logic [W-1:0] prev_q,
   output logic         change
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now_q  <= '0;
         prev_q <= '0;
      end else begin
         now_q  <= live;
         prev_q <= now_q;
      end
   end

   assign change = |(now_q ^ prev_q);

endmodule

// File: rtl/phy_regbank_irq.sv
module phy_regbank_irq
   import phy_regbank_pkg::*;
#(
   parameter logic [REG_W-1:0] MASK = 8'h1E
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] src_now,
   input  logic [REG_W-1:0] src_prev,
   input  logic [REG_W-1:0] en_rise,
   input  logic [REG_W-1:0] en_fall,
   input  logic             clr_stb,
   input  logic [REG_W-1:0] clr_bits,
   output logic [REG_W-1:0] latch
);

   logic [REG_W-1:0] rise_ev, fall_ev, clr_m;

   assign rise_ev = src_now & ~src_prev & en_rise & MASK;
   assign fall_ev = ~src_now & src_prev & en_fall & MASK;
   assign clr_m   = clr_stb ? clr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch <= '0;
      else        latch <= ((latch & ~clr_m) | rise_ev | fall_ev) & MASK;
   end

endmodule

// File: rtl/phy_regbank.sv
module phy_regbank
   import phy_regbank_pkg::*;
#(
   parameter int               ADDR_W     = 6,
   parameter logic [15:0]      VENDOR_ID  = 16'hA5C3,
   parameter logic [15:0]      PRODUCT_ID = 16'h3E71,
   parameter logic [REG_W-1:0] FUNC_MASK  = 8'h7F,
   parameter logic [REG_W-1:0] INTF_MASK  = 8'h9F,
   parameter logic [REG_W-1:0] OTG_MASK   = 8'hFF,
   parameter logic [REG_W-1:0] IRQ_MASK   = 8'h1E,
   parameter logic [REG_W-1:0] FUNC_RST   = 8'h41,
   parameter logic [REG_W-1:0] INTF_RST   = 8'h00,
   parameter logic [REG_W-1:0] OTG_RST    = 8'h06,
   parameter logic [REG_W-1:0] IRQ_EN_RST = 8'h1E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic              vbus_valid,
   input  logic              sess_valid,
   input  logic              sess_end,
   input  logic              id_gnd,
   input  logic [1:0]        line_state,
   output logic [7:0]        func_ctrl,
   output logic [7:0]        intf_ctrl,
   output logic [7:0]        otg_ctrl,
   output logic              irq_pending,
   output logic              status_change
);

   localparam int CTL_BASE   = 4;
   localparam int IDX_FUNC   = 0;
   localparam int IDX_INTF   = 1;
   localparam int IDX_OTG    = 2;
   localparam int IDX_ERISE  = 3;
   localparam int IDX_EFALL  = 4;
   localparam int LATCH_ADDR = CTL_BASE + ALIASES * NUM_CTL;
   localparam int LCLR_ADDR  = LATCH_ADDR + 1;
   localparam int DBG_ADDR   = LATCH_ADDR + 2;
   localparam int SENSE_W    = 6;

   localparam logic [REG_W*NUM_CTL-1:0] CTL_MASKS =
      {IRQ_MASK, IRQ_MASK, OTG_MASK, INTF_MASK, FUNC_MASK};
   localparam logic [REG_W*NUM_CTL-1:0] CTL_RSTS =
      {IRQ_EN_RST, IRQ_EN_RST, OTG_RST, INTF_RST, FUNC_RST};

   generate
      if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr_w
         $error("phy_regbank: ADDR_W must lie in 5..8");
      end
      if ((IRQ_MASK & 8'hE1) != 8'h00) begin : g_bad_irq_mask
         $error("phy_regbank: IRQ_MASK may only cover bits 4:1");
      end
   endgenerate

   logic [REG_W-1:0] ctl_q [NUM_CTL];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CTL; gi++) begin : g_ctl
         phy_regbank_alias #(
            .ADDR_W (ADDR_W),
            .BASE   (CTL_BASE + ALIASES * gi),
            .MASK   (CTL_MASKS[gi*REG_W +: REG_W]),
            .RST    (CTL_RSTS[gi*REG_W +: REG_W])
         ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .q       (ctl_q[gi])
         );
      end
   endgenerate

   logic [SENSE_W-1:0] live, now_q, prev_q;

   assign live = {line_state, id_gnd, sess_end, sess_valid, vbus_valid};

   phy_regbank_sense #(.W(SENSE_W)) u_sense (
      .clk    (clk),
      .rst_n  (rst_n),
      .live   (live),
      .now_q  (now_q),
      .prev_q (prev_q),
      .change (status_change)
   );

   logic [REG_W-1:0] src_now, src_prev, latch;
   logic             clr_stb;

   assign src_now  = {3'b000, now_q[3:0], 1'b0};
   assign src_prev = {3'b000, prev_q[3:0], 1'b0};
   assign clr_stb  = wr_en && (wr_addr == ADDR_W'(LCLR_ADDR));

   phy_regbank_irq #(.MASK(IRQ_MASK)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_now  (src_now),
      .src_prev (src_prev),
      .en_rise  (ctl_q[IDX_ERISE]),
      .en_fall  (ctl_q[IDX_EFALL]),
      .clr_stb  (clr_stb),
      .clr_bits (wr_data),
      .latch    (latch)
   );

   assign irq_pending = |latch;
   assign func_ctrl   = ctl_q[IDX_FUNC];
   assign intf_ctrl   = ctl_q[IDX_INTF];
   assign otg_ctrl    = ctl_q[IDX_OTG];

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(0):          rd_data = VENDOR_ID[7:0];
         ADDR_W'(1):          rd_data = VENDOR_ID[15:8];
         ADDR_W'(2):          rd_data = PRODUCT_ID[7:0];
         ADDR_W'(3):          rd_data = PRODUCT_ID[15:8];
         ADDR_W'(LATCH_ADDR): rd_data = latch;
         ADDR_W'(LCLR_ADDR):  rd_data = latch;
         ADDR_W'(DBG_ADDR):   rd_data = {6'b000000, now_q[5:4]};
         default:             rd_data = '0;
      endcase
      for (int i = 0; i < NUM_CTL; i++) begin
         if (rd_addr >= ADDR_W'(CTL_BASE + ALIASES * i) &&
             rd_addr <= ADDR_W'(CTL_BASE + ALIASES * i + ALIASES - 1))
            rd_data = ctl_q[i];
      end
   end

endmodule

// File: rtl/phy_regbank_chk.sv
module phy_regbank_chk #(
   parameter int          ADDR_W    = 6,
   parameter logic [7:0]  FUNC_MASK = 8'h7F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [7:0]        rd_data,
   input logic [7:0]        func_ctrl,
   input logic              irq_pending
);

   // R3: reserved function bits never read back as 1
   p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (func_ctrl & ~FUNC_MASK) == 8'h00);

   // R4: after an OR-alias write every written implemented bit is set
   p_set_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(5)) |=>
      ((func_ctrl & $past(wr_data) & FUNC_MASK) == ($past(wr_data) & FUNC_MASK)));

   // R5: after a clear-alias write every written bit is 0
   p_clr_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(6)) |=> ((func_ctrl & $past(wr_data)) == 8'h00));

   // R12: a cycle without a write leaves the control register unchanged
   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(func_ctrl));

   // R9: pending stays up until a latch-clear write
   p_pending_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pending && !(wr_en && wr_addr == ADDR_W'(20))) |=> irq_pending);

   // R12: unmapped reads return zero
   p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr > ADDR_W'(21)) |-> (rd_data == 8'h00));

endmodule

bind phy_regbank phy_regbank_chk #(.ADDR_W(ADDR_W), .FUNC_MASK(FUNC_MASK)) u_chk (.*);

// File: tb/phy_regbank_tb.sv
`timescale 1ns/1ps
module phy_regbank_tb;

   localparam logic [7:0] MASKS [5] = '{8'h7F, 8'h9F, 8'hFF, 8'h1E, 8'h1E};
   localparam logic [7:0] RSTS  [5] = '{8'h41, 8'h00, 8'h06, 8'h1E, 8'h1E};
   localparam logic [5:0] A_LAT = 6'h13;
   localparam logic [5:0] A_CLR = 6'h14;
   localparam logic [5:0] A_DBG = 6'h15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [5:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [5:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       vbus_valid = 1'b0, sess_valid = 1'b0, sess_end = 1'b0, id_gnd = 1'b0;
   logic [1:0] line_state = 2'b00;
   logic [7:0] func_ctrl, intf_ctrl, otg_ctrl;
   logic       irq_pending, status_change;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] model [5];

   always #2.5 clk = ~clk;

   phy_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .vbus_valid(vbus_valid),
      .sess_valid(sess_valid), .sess_end(sess_end), .id_gnd(id_gnd),
      .line_state(line_state), .func_ctrl(func_ctrl), .intf_ctrl(intf_ctrl),
      .otg_ctrl(otg_ctrl), .irq_pending(irq_pending), .status_change(status_change)
   );

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
      end
   endtask

   // call at a falling edge; returns at the next falling edge
   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic set_src(input int s, input logic v);
      case (s)
         1: vbus_valid = v;
         2: sess_valid = v;
         3: sess_end   = v;
         default: id_gnd = v;
      endcase
   endtask

   function automatic logic [5:0] base_of(input int r);
      return 6'(4 + 3 * r);
   endfunction

   task automatic check_all_regs(input string tag);
      logic [7:0] v;
      for (int r = 0; r < 5; r++) begin
         for (int k = 0; k < 3; k++) begin
            rd(base_of(r) + 6'(k), v);
            check(tag, v, model[r]);
         end
      end
      check({tag, " func port"}, func_ctrl, model[0]);
      check({tag, " intf port"}, intf_ctrl, model[1]);
      check({tag, " otg port"},  otg_ctrl,  model[2]);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0] v, d, d2, d3;
      logic [7:0] er, ef;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      for (int r = 0; r < 5; r++) model[r] = RSTS[r];
      check_all_regs("R1 reset");
      rd(A_LAT, v); check("R1 latch reset", v, 8'h00);
      check("R1 pending reset", {7'b0, irq_pending}, 8'h00);
      check("R1 change reset", {7'b0, status_change}, 8'h00);
      rd(A_DBG, v); check("R11 debug reset", v, 8'h00);

      // R2 identification bytes
      rd(6'h00, v); check("R2 vid lo", v, 8'hC3);
      rd(6'h01, v); check("R2 vid hi", v, 8'hA5);
      rd(6'h02, v); check("R2 pid lo", v, 8'h71);
      rd(6'h03, v); check("R2 pid hi", v, 8'h3E);

      // R3 R4 R5 R6 full sweep of every control register
      for (int r = 0; r < 5; r++) begin
         for (int p = 0; p < 256; p++) begin
            d  = 8'(p);
            d2 = {d[3:0], d[7:4]} ^ 8'h5A;
            d3 = ~d ^ 8'h33;
            wr(base_of(r), d);
            model[r] = d & MASKS[r];
            rd(base_of(r), v); check("R3 load", v, model[r]);
            wr(base_of(r) + 6'd1, d2);
            model[r] = model[r] | (d2 & MASKS[r]);
            rd(base_of(r) + 6'd1, v); check("R4 set", v, model[r]);
            wr(base_of(r) + 6'd2, d3);
            model[r] = model[r] & ~d3;
            rd(base_of(r) + 6'd2, v); check("R5 clear", v, model[r]);
         end
         check_all_regs("R6 aliases");
      end

      // R7 R9 R10 edge qualification per source and enable combination
      wr(A_CLR, 8'hFF);
      for (int s = 1; s <= 4; s++) begin
         for (int c = 0; c < 4; c++) begin
            er = c[0] ? 8'(1 << s) : 8'h00;
            ef = c[1] ? 8'(1 << s) : 8'h00;
            wr(6'h0D, er); wr(6'h10, ef); wr(A_CLR, 8'hFF);
            set_src(s, 1'b1);
            @(negedge clk);
            check("R10 pulse rise", {7'b0, status_change}, 8'h01);
            @(negedge clk);
            check("R10 pulse ends", {7'b0, status_change}, 8'h00);
            rd(A_LAT, v); check("R7 rise latch", v, er);
            check("R9 pending", {7'b0, irq_pending}, {7'b0, er != 8'h00});
            wr(A_CLR, 8'hFF);
            rd(A_LAT, v); check("R8 clear all", v, 8'h00);
            set_src(s, 1'b0);
            @(negedge clk); @(negedge clk);
            rd(A_LAT, v); check("R7 fall latch", v, ef);
            check("R9 pending fall", {7'b0, irq_pending}, {7'b0, ef != 8'h00});
            wr(A_CLR, 8'hFF);
         end
      end
      model[3] = 8'h10; model[4] = 8'h10;

      // R8 partial clear and ignored write to 13h
      wr(6'h0D, 8'h1E); wr(6'h10, 8'h00);
      model[3] = 8'h1E; model[4] = 8'h00;
      vbus_valid = 1'b1; sess_valid = 1'b1; sess_end = 1'b1; id_gnd = 1'b1;
      @(negedge clk); @(negedge clk);
      rd(A_LAT, v); check("R7 all rise", v, 8'h1E);
      wr(A_CLR, 8'h06);
      rd(A_LAT, v); check("R8 partial clear", v, 8'h18);
      wr(A_LAT, 8'hFF);
      rd(A_LAT, v); check("R8 write 13h ignored", v, 8'h18);
      wr(A_CLR, 8'hFF);
      vbus_valid = 1'b0; sess_valid = 1'b0; sess_end = 1'b0; id_gnd = 1'b0;
      @(negedge clk); @(negedge clk);
      rd(A_LAT, v); check("R7 disabled falls", v, 8'h00);
      check("R9 pending low", {7'b0, irq_pending}, 8'h00);

      // R8 event on the clearing edge wins
      id_gnd = 1'b1;
      @(negedge clk);
      wr(A_CLR, 8'hFF);
      rd(A_LAT, v); check("R8 event beats clear", v, 8'h10);
      wr(A_CLR, 8'hFF);
      id_gnd = 1'b0;
      @(negedge clk); @(negedge clk);

      // R10 R11 line state stepping
      for (int k = 1; k <= 4; k++) begin
         line_state = 2'(k);
         @(negedge clk);
         check("R10 line pulse", {7'b0, status_change}, 8'h01);
         rd(A_DBG, v); check("R11 debug", v, {6'b0, 2'(k)});
         @(negedge clk);
         check("R10 line pulse ends", {7'b0, status_change}, 8'h00);
      end

      // R12 unmapped reads, and writes to read-only or unmapped addresses
      for (int a = 8'h16; a < 64; a++) begin
         rd(6'(a), v); check("R12 unmapped read", v, 8'h00);
      end
      wr(6'h16, 8'hFF); wr(6'h3F, 8'hFF); wr(6'h00, 8'hFF); wr(6'h03, 8'h00); wr(A_DBG, 8'hFF);
      check_all_regs("R12 stray writes");
      rd(6'h00, v); check("R2 vid after write", v, 8'hC3);
      rd(6'h03, v); check("R2 pid after write", v, 8'h3E);
      rd(A_LAT, v); check("R12 latch untouched", v, 8'h00);
      rd(A_DBG, v); check("R11 debug after write", v, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule